// File: doc/BRIEF.md
# Hamming-Protected Byte Store with Correction Status

This block keeps a small array of bytes on chip and guards each byte with a single-error-correcting Hamming code. Every write encodes the byte into a 12-bit codeword, and the codeword is what gets stored. Every read recomputes the parity over the stored codeword and forms a syndrome. When the syndrome points at a flipped bit, the block repairs that bit before it returns the byte. The stored word itself is not rewritten.

Corrections are not hidden. A sticky status flag records that a repair happened. Next to it sits the index of the storage block that produced the most recent repair. A host can read the byte and ignore it, look only at the status, and retire a worn block without comparing any data. A second sticky flag reports syndromes that cannot name a real bit position. A diagnostic mask on the write port can flip chosen codeword bits as they are stored, so faults can be planted on purpose.

Top module: `ecc_status_mem`

## Requirements
- R1: A byte written to an address and read back with no planted fault is returned on `rd_data` unchanged. `rd_valid` is high in exactly the cycle after each clock edge that samples `rd_en`, and the status outputs do not change.
- R2: Codeword position p (1..12) is stored in bit p-1 of `wr_flip`. Check bits sit at positions 1, 2, 4 and 8. Data bits 0..7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. A single flipped data position is repaired, the original byte is returned, and `stat_corr` is set.
- R3: A single flipped check position (1, 2, 4 or 8) leaves the returned byte equal to the written byte, and it still sets `stat_corr`.
- R4: A syndrome of 13, 14 or 15 changes no data bit. The byte is returned as stored, with any planted flips left in place. `stat_uncorr` is set, while `stat_corr` and `stat_blk` keep their values.
- R5: On a repaired read, `stat_blk` takes the block index of the read address, which is `rd_addr >> BLK_LOG2`. A later read that needs no repair leaves `stat_blk` as it is.
- R6: `stat_corr` and `stat_uncorr` stay set until a clear. If a clear and a read that sets a flag are sampled at the same edge, the flag ends up set.
- R7: After reset, `rd_valid`, `rd_data`, `stat_corr`, `stat_uncorr` and `stat_blk` are all zero.
- R8: A read and a write to the same address in the same cycle return the contents that were there before that write.
- R9: While `rd_en` is low, `rd_data` holds its value and the status outputs do not change, unless a clear is applied.
- R10: A `stat_clr` pulse with no read in the same cycle sets both flags and `stat_blk` to zero at the next edge.
- R11: Two planted flips whose syndrome lands in 1..12 produce a miscorrection of the position named by the syndrome, and `stat_corr` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Byte to store |
| wr_flip | input | 12 | Diagnostic mask XORed into the stored codeword |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Corrected byte, valid one cycle after the request |
| rd_valid | output | 1 | High for one cycle after each read request |
| stat_clr | input | 1 | Clears the status flags and block index |
| stat_corr | output | 1 | Sticky: a correction has been applied |
| stat_uncorr | output | 1 | Sticky: a syndrome pointed beyond position 12 |
| stat_blk | output | ADDR_W-BLK_LOG2 | Block index of the most recent corrected read |

## Verification
A wrong encoder or a wrong syndrome mapping does not stay hidden. It shows up in the very next read as a wrong byte, or as a status flag raised on a clean word, one cycle after the request. A status register that loses its state, or updates when it should not, shows up at the first read or idle cycle after the event. That is why every fault vector is preceded by a clear and followed by a status check. The sweep covers every byte value, every single-position fault and every pair of positions, so any error in the position map shows up as at least one wrong byte.

// File: rtl/ecc_status_pkg.sv
`timescale 1ns/1ps
package ecc_status_pkg;

    localparam int DATA_W = 8;
    localparam int CW_W   = 12;
    localparam int SYN_W  = 4;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [SYN_W-1:0]  syn_t;

    // outcome of decoding one stored codeword
    typedef enum logic [1:0] {
        SYN_CLEAN  = 2'd0,
        SYN_DATA   = 2'd1,
        SYN_CHECK  = 2'd2,
        SYN_BEYOND = 2'd3
    } syn_kind_e;

    typedef struct packed {
        byte_t     data;
        syn_kind_e kind;
    } dec_res_t;

    // positions that are powers of two hold check bits
    function automatic logic is_check_pos(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // XOR of the 1-based positions of every set bit
    function automatic syn_t syndrome(input cw_t cw);
        syn_t s = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw[p-1]) s ^= syn_t'(p);
        end
        return s;
    endfunction

    function automatic cw_t place_data(input byte_t d);
        cw_t cw = '0;
        int  k  = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_check_pos(p)) begin
                cw[p-1] = d[k];
                k++;
            end
        end
        return cw;
    endfunction

    function automatic byte_t pick_data(input cw_t cw);
        byte_t d = '0;
        int    k = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_check_pos(p)) begin
                d[k] = cw[p-1];
                k++;
            end
        end
        return d;
    endfunction

    // check bits chosen so that the whole word has a zero syndrome
    function automatic cw_t encode(input byte_t d);
        cw_t  cw = place_data(d);
        syn_t s  = syndrome(cw);
        for (int b = 0; b < SYN_W; b++) begin
            cw[(1 << b) - 1] = s[b];
        end
        return cw;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
`timescale 1ns/1ps
module ecc_enc
    import ecc_status_pkg::*;
(
    input  byte_t data,
    input  cw_t   flip,
    output cw_t   cw
);

    always_comb begin
        cw = encode(data) ^ flip;
    end

endmodule

// File: rtl/ecc_store.sv
`timescale 1ns/1ps
module ecc_store
    import ecc_status_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  cw_t               wcw,
    input  logic [ADDR_W-1:0] raddr,
    output cw_t               rcw
);

    localparam int DEPTH = 1 << ADDR_W;

    cw_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wcw;
    end

    // asynchronous read: a same-edge write is not yet visible
    assign rcw = mem[raddr];

endmodule

// File: rtl/ecc_dec.sv
`timescale 1ns/1ps
module ecc_dec
    import ecc_status_pkg::*;
(
    input  cw_t      cw,
    output dec_res_t res
);

    syn_t syn;
    cw_t  fixed;

    always_comb begin
        syn   = syndrome(cw);
        fixed = cw;
        if (syn == '0) begin
            res.kind = SYN_CLEAN;
        end else if (syn > syn_t'(CW_W)) begin
            res.kind = SYN_BEYOND;
        end else begin
            fixed    = cw ^ (cw_t'(1) << (syn - syn_t'(1)));
            res.kind = is_check_pos(int'(syn)) ? SYN_CHECK : SYN_DATA;
        end
        res.data = pick_data(fixed);
    end

endmodule

// File: rtl/ecc_stat.sv
`timescale 1ns/1ps
module ecc_stat
    import ecc_status_pkg::*;
#(
    parameter int BLK_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  syn_kind_e        kind,
    input  logic [BLK_W-1:0] blk,
    input  logic             clr,
    output logic             corr,
    output logic             uncorr,
    output logic [BLK_W-1:0] blk_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            corr   <= 1'b0;
            uncorr <= 1'b0;
            blk_q  <= '0;
        end else begin
            if (clr) begin
                corr   <= 1'b0;
                uncorr <= 1'b0;
                blk_q  <= '0;
            end
            // a setting event overrides a clear at the same edge
            if (upd && (kind == SYN_DATA || kind == SYN_CHECK)) begin
                corr  <= 1'b1;
                blk_q <= blk;
            end
            if (upd && kind == SYN_BEYOND) begin
                uncorr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecc_status_mem.sv
`timescale 1ns/1ps
module ecc_status_mem
    import ecc_status_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int BLK_LOG2 = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic [11:0]                wr_flip,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data,
    output logic                       rd_valid,
    input  logic                       stat_clr,
    output logic                       stat_corr,
    output logic                       stat_uncorr,
    output logic [ADDR_W-BLK_LOG2-1:0] stat_blk
);

    localparam int BLK_W = ADDR_W - BLK_LOG2;

    cw_t      wr_cw;
    cw_t      rd_cw;
    dec_res_t dec;

    ecc_enc u_enc (
        .data (wr_data),
        .flip (wr_flip),
        .cw   (wr_cw)
    );

    ecc_store #(.ADDR_W(ADDR_W)) u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wcw   (wr_cw),
        .raddr (rd_addr),
        .rcw   (rd_cw)
    );

    ecc_dec u_dec (
        .cw  (rd_cw),
        .res (dec)
    );

    ecc_stat #(.BLK_W(BLK_W)) u_stat (
        .clk    (clk),
        .rst    (rst),
        .upd    (rd_en),
        .kind   (dec.kind),
        .blk    (rd_addr[ADDR_W-1:BLK_LOG2]),
        .clr    (stat_clr),
        .corr   (stat_corr),
        .uncorr (stat_uncorr),
        .blk_q  (stat_blk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= dec.data;
        end
    end

endmodule

// File: rtl/ecc_status_chk.sv
`timescale 1ns/1ps
module ecc_status_chk #(
    parameter int BLK_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic             rd_valid,
    input logic [7:0]       rd_data,
    input logic             stat_clr,
    input logic             stat_corr,
    input logic             stat_uncorr,
    input logic [BLK_W-1:0] stat_blk
);

    // R1
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R6
    corr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_corr && !stat_clr) |=> stat_corr);

    // R6
    uncorr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_uncorr && !stat_clr) |=> stat_uncorr);

    // R9
    idle_status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !stat_clr) |=> ($stable(stat_corr) && $stable(stat_uncorr) && $stable(stat_blk)));

    // R9
    idle_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R10
    clear_wins_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !rd_en) |=> (!stat_corr && !stat_uncorr && stat_blk == '0));

endmodule

bind ecc_status_mem ecc_status_chk #(.BLK_W(ADDR_W - BLK_LOG2)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .stat_clr    (stat_clr),
    .stat_corr   (stat_corr),
    .stat_uncorr (stat_uncorr),
    .stat_blk    (stat_blk)
);

// File: tb/ecc_status_mem_tb.sv
`timescale 1ns/1ps
module ecc_status_mem_tb;

    localparam int ADDR_W   = 4;
    localparam int BLK_LOG2 = 2;
    localparam int BLK_W    = ADDR_W - BLK_LOG2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [11:0]       wr_flip = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              rd_valid;
    logic              stat_clr = 1'b0;
    logic              stat_corr;
    logic              stat_uncorr;
    logic [BLK_W-1:0]  stat_blk;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    ecc_status_mem #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_flip(wr_flip),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .stat_clr(stat_clr), .stat_corr(stat_corr), .stat_uncorr(stat_uncorr),
        .stat_blk(stat_blk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // byte after inverting the data bits named by a position mask
    function automatic logic [7:0] flip_bits(input logic [7:0] d, input logic [11:0] m);
        logic [7:0] r = d;
        int k = 0;
        for (int p = 1; p <= 12; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (m[p-1]) r[k] = ~r[k];
                k++;
            end
        end
        return r;
    endfunction

    function automatic int mask_syn(input logic [11:0] m);
        int s = 0;
        for (int p = 1; p <= 12; p++) if (m[p-1]) s ^= p;
        return s;
    endfunction

    task automatic do_write(input int a, input logic [7:0] d, input logic [11:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; wr_flip = m;
        @(negedge clk);
        wr_en = 1'b0; wr_flip = '0;
    endtask

    task automatic do_read(input int a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    // clear, store with a planted mask, read back, compare with the model
    task automatic run_vec(input int a, input logic [7:0] d, input logic [11:0] m);
        int         s;
        logic [7:0] exp_d;
        logic       exp_c, exp_u;
        string      tag;
        do_clear();
        do_write(a, d, m);
        do_read(a);
        s = mask_syn(m);
        exp_c = 1'b0; exp_u = 1'b0;
        if (s == 0) begin
            exp_d = d; tag = "R1";
        end else if (s > 12) begin
            exp_d = flip_bits(d, m); exp_u = 1'b1; tag = "R4";
        end else begin
            exp_d = flip_bits(d, m ^ (12'd1 << (s - 1))); exp_c = 1'b1;
            if ($countones(m) > 1)      tag = "R11";
            else if ((s & (s - 1)) == 0) tag = "R3";
            else                         tag = "R2";
        end
        chk({tag, " data"}, 32'(rd_data), 32'(exp_d));
        chk({tag, " valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " corr"}, 32'(stat_corr), 32'(exp_c));
        chk({tag, " uncorr"}, 32'(stat_uncorr), 32'(exp_u));
        chk("R5 blk", 32'(stat_blk), exp_c ? 32'(a >> BLK_LOG2) : 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7 reset state
        chk("R7 valid", 32'(rd_valid), 32'd0);
        chk("R7 data", 32'(rd_data), 32'd0);
        chk("R7 corr", 32'(stat_corr), 32'd0);
        chk("R7 uncorr", 32'(stat_uncorr), 32'd0);
        chk("R7 blk", 32'(stat_blk), 32'd0);

        // R1 every byte value, clean
        for (int d = 0; d < 256; d++) run_vec(d % 16, 8'(d), 12'd0);

        // R2 / R3 every single position over several bytes
        for (int p = 1; p <= 12; p++)
            for (int k = 0; k < 16; k++)
                run_vec((p + k) % 16, 8'(p * 37 + k * 29), 12'd1 << (p - 1));

        // R4 / R11 every pair of positions
        for (int i = 1; i <= 12; i++)
            for (int j = i + 1; j <= 12; j++)
                run_vec((i * 3 + j) % 16, 8'(i * 11 ^ j * 23),
                        (12'd1 << (i - 1)) | (12'd1 << (j - 1)));

        // R5 most recent correction wins; a clean read leaves blk alone
        do_clear();
        do_write(1, 8'h3c, 12'h004);
        do_write(13, 8'hc3, 12'h010);
        do_write(6, 8'h5a, 12'h000);
        do_read(1);
        do_read(13);
        chk("R5 latest blk", 32'(stat_blk), 32'd3);
        do_read(6);
        chk("R5 clean keeps blk", 32'(stat_blk), 32'd3);
        chk("R6 corr sticky", 32'(stat_corr), 32'd1);

        // R4 beyond syndrome keeps corr and blk
        do_write(9, 8'h77, 12'h890);  // positions 5, 8, 12 -> syndrome 1 (R11 not wanted)
        do_write(10, 8'h77, 12'h090); // positions 5 and 8 -> syndrome 13
        do_read(10);
        chk("R4 blk kept", 32'(stat_blk), 32'd3);
        chk("R4 corr kept", 32'(stat_corr), 32'd1);
        chk("R4 uncorr", 32'(stat_uncorr), 32'd1);

        // R9 idle cycles hold data and status
        held = rd_data;
        repeat (4) @(negedge clk);
        chk("R9 data hold", 32'(rd_data), 32'(held));
        chk("R9 valid low", 32'(rd_valid), 32'd0);
        chk("R9 corr hold", 32'(stat_corr), 32'd1);

        // R10 clear pulse
        do_clear();
        chk("R10 corr", 32'(stat_corr), 32'd0);
        chk("R10 uncorr", 32'(stat_uncorr), 32'd0);
        chk("R10 blk", 32'(stat_blk), 32'd0);

        // R6 clear together with a correcting read: set wins
        @(negedge clk);
        stat_clr = 1'b1; rd_en = 1'b1; rd_addr = 4'd1;
        @(negedge clk);
        stat_clr = 1'b0; rd_en = 1'b0;
        chk("R6 set beats clear", 32'(stat_corr), 32'd1);
        chk("R6 set beats clear blk", 32'(stat_blk), 32'd0);
        chk("R2 data", 32'(rd_data), 32'h3c);

        // R8 read and write of one address in the same cycle
        do_write(4, 8'h11, 12'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd4; wr_data = 8'hee;
        rd_en = 1'b1; rd_addr = 4'd4;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R8 old contents", 32'(rd_data), 32'h11);
        do_read(4);
        chk("R8 new contents", 32'(rd_data), 32'hee);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule